// File: doc/BRIEF.md
# Control Endpoint Buffer Controller

This block manages endpoint zero of a USB function. A single 16-byte buffer carries payloads both ways: SETUP and OUT payloads from the host are written into it for the microcontroller to read, and IN payloads that the microcontroller writes into it are sent to the host. The block sits between a packet-level port and a small register port. The packet-level port carries decoded tokens, received data beats and the host's handshake, and it takes back handshakes and transmit data. The microcontroller side is a register port with three addresses.

The block keeps the DATA0/DATA1 sequence bit across a multi-packet control transfer. It holds the last IN payload until the host acknowledges it, so a retried IN token is answered with the same bytes and the same sequence bit, and firmware takes no part in the retry. A firmware-controlled halt bit makes the endpoint answer STALL. A SETUP packet always gets through and lifts the halt.

Top module: `ep0c_top`

## Requirements
- R1: After synchronous reset no handshake or transmit output is active, and both the status register and the auxiliary register read 0.
- R2: A SETUP token (tok_kind 2) is accepted in any state, including while halted. A following error-free data packet is answered with ACK (hs_code 0). The halt bit is cleared, the sequence bit becomes 1 (DATA1), and status shows the byte count with pending (bit 5) and setup (bit 6) set.
- R3: An OUT token (tok_kind 0) is accepted when the buffer is empty, not armed and not pending. An error-free packet whose rx_toggle equals the sequence bit is ACKed, its bytes (possibly zero) are read from address 0 in arrival order, and the sequence bit flips.
- R4: An accepted OUT packet whose rx_toggle differs from the sequence bit is ACKed. Its data is discarded, with count 0 and pending 0, and the sequence bit is unchanged.
- R5: An OUT that is not accepted is answered with NAK (hs_code 1) after its data and leaves the buffer untouched. An IN token (tok_kind 1) while not armed is answered with NAK.
- R6: An IN token while armed produces tx_pkt for one cycle with tx_len equal to the loaded byte count and tx_toggle equal to the sequence bit. On the following tx_len cycles tx_valid is high and tx_data carries the bytes in load order.
- R7: If no host_ack follows an IN packet, the next IN token sends the same bytes with the same tx_toggle.
- R8: host_ack after an IN packet flips the sequence bit, clears armed and empties the buffer.
- R9: While the halt bit is set (control write bit 2), IN tokens and OUT data packets are answered with STALL (hs_code 2). Clearing it (control write bit 3) restores normal answers.
- R10: An accepted packet with rx_crc_ok low at rx_end, or with more than 16 data bytes, gets no handshake and leaves the buffer empty. Exactly 16 bytes are accepted.
- R11: Register map. Address 0: a write appends a byte (ignored while armed, pending, receiving or full) and a read returns the next received byte and advances. Address 1: a write with bit 0 arms IN, bit 1 releases received data, bit 2 sets halt and bit 3 clears halt; a read returns {halt, setup, pending, count[4:0]}. Address 2: a read returns {6'b0, sequence bit, armed}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token for this endpoint present this cycle |
| tok_kind | input | 2 | 0 OUT, 1 IN, 2 SETUP |
| rx_valid | input | 1 | Received data byte present |
| rx_data | input | 8 | Received data byte |
| rx_end | input | 1 | End of received data packet (separate beat) |
| rx_toggle | input | 1 | Sequence bit of the received data packet |
| rx_crc_ok | input | 1 | Packet check good, sampled with rx_end |
| host_ack | input | 1 | Host acknowledged the last IN packet |
| hs_valid | output | 1 | Handshake to send this cycle |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL |
| tx_pkt | output | 1 | Start of IN data packet |
| tx_len | output | 5 | Byte count of the IN packet |
| tx_toggle | output | 1 | Sequence bit of the IN packet |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| mcu_sel | input | 1 | Register access this cycle |
| mcu_we | input | 1 | 1 write, 0 read |
| mcu_addr | input | 2 | Register address |
| mcu_wdata | input | 8 | Write data |
| mcu_rdata | output | 8 | Read data (combinational) |

## Verification
On every cycle the assertions check the following: the byte count stays within the buffer, a handshake and a packet start never occur together, a halted or unarmed endpoint answers an IN as required, an acknowledged IN flips the sequence bit, and SETUP and mismatched OUT packets leave the expected sequence and pending state. Whole behaviours over several packets can only be shown by the bench's scenarios. These are the byte-exact replay of an unacknowledged IN, the order of data read back, NAK leaving the held data intact, the 16-versus-17-byte boundary, zero-length packets both ways and the halt being lifted by SETUP.

// File: rtl/ep0c_pkg.sv
package ep0c_pkg;

    localparam int DW = 8;

    typedef enum logic [1:0] {
        TOK_OUT   = 2'd0,
        TOK_IN    = 2'd1,
        TOK_SETUP = 2'd2
    } tok_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2
    } hs_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RXACC,
        ST_RXDROP,
        ST_TX,
        ST_WAIT
    } st_e;

    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_AUX  = 2'd2;

    typedef struct packed {
        logic          push;
        logic          pop;
        logic          arm;
        logic          drop;
        logic          halt_set;
        logic          halt_clr;
        logic [DW-1:0] wbyte;
    } mcu_cmd_t;

    function automatic logic [DW-1:0] pack_status(logic halt, logic setup,
                                                  logic pend, logic [4:0] cnt);
        return {halt, setup, pend, cnt};
    endfunction

endpackage

// File: rtl/ep0c_store.sv
module ep0c_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/ep0c_mcu.sv
module ep0c_mcu
    import ep0c_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          sel,
    input  logic          we,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] cnt,
    input  logic          pend,
    input  logic          setup,
    input  logic          halt,
    input  logic          armed,
    input  logic          tog,
    input  logic [DW-1:0] rbyte,
    output mcu_cmd_t      cmd,
    output logic [DW-1:0] rdata
);
    logic wr_ctrl;

    assign wr_ctrl = sel && we && (addr == REG_CTRL);

    always_comb begin
        cmd          = '0;
        cmd.wbyte    = wdata;
        cmd.push     = sel && we && (addr == REG_DATA);
        cmd.pop      = sel && !we && (addr == REG_DATA);
        cmd.arm      = wr_ctrl && wdata[0];
        cmd.drop     = wr_ctrl && wdata[1];
        cmd.halt_set = wr_ctrl && wdata[2];
        cmd.halt_clr = wr_ctrl && wdata[3];
    end

    always_comb begin
        case (addr)
            REG_DATA: rdata = rbyte;
            REG_CTRL: rdata = pack_status(halt, setup, pend, 5'(cnt));
            REG_AUX:  rdata = {{(DW-2){1'b0}}, tog, armed};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/ep0c_proto.sv
module ep0c_proto
    import ep0c_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tok_valid,
    input  logic [1:0]    tok_kind,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_end,
    input  logic          rx_toggle,
    input  logic          rx_crc_ok,
    input  logic          host_ack,
    input  mcu_cmd_t      cmd,
    output logic          hs_valid,
    output logic [1:0]    hs_code,
    output logic          tx_pkt,
    output logic [CW-1:0] tx_len,
    output logic          tx_toggle,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] mem_raddr_mcu,
    output logic [AW-1:0] mem_raddr_tx,
    input  logic [DW-1:0] mem_rdata_tx,
    output logic [CW-1:0] cnt,
    output logic          pend,
    output logic          is_setup,
    output logic          halt,
    output logic          armed,
    output logic          tog
);
    st_e           st;
    tok_e          tk;
    logic          rx_setup;
    logic          ovf;
    logic [CW-1:0] rptr;
    logic [CW-1:0] tidx;
    logic          push_ok;
    logic          pop_ok;
    logic          rx_wr;
    logic          room;

    assign tk      = tok_e'(tok_kind);
    assign room    = cnt < CW'(DEPTH);
    assign push_ok = cmd.push && !armed && !pend && (st != ST_RXACC) && room;
    assign pop_ok  = cmd.pop && pend && (rptr < cnt);
    assign rx_wr   = (st == ST_RXACC) && rx_valid && room;

    assign mem_we        = rx_wr || push_ok;
    assign mem_waddr     = cnt[AW-1:0];
    assign mem_wdata     = rx_wr ? rx_data : cmd.wbyte;
    assign mem_raddr_mcu = rptr[AW-1:0];
    assign mem_raddr_tx  = tidx[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            tog       <= 1'b0;
            halt      <= 1'b0;
            armed     <= 1'b0;
            pend      <= 1'b0;
            is_setup  <= 1'b0;
            rx_setup  <= 1'b0;
            ovf       <= 1'b0;
            cnt       <= '0;
            rptr      <= '0;
            tidx      <= '0;
            hs_valid  <= 1'b0;
            hs_code   <= HS_ACK;
            tx_pkt    <= 1'b0;
            tx_len    <= '0;
            tx_toggle <= 1'b0;
            tx_valid  <= 1'b0;
            tx_data   <= '0;
        end else begin
            hs_valid <= 1'b0;
            tx_pkt   <= 1'b0;
            tx_valid <= 1'b0;

            // firmware side
            if (push_ok) cnt <= cnt + CW'(1);
            if (pop_ok)  rptr <= rptr + CW'(1);
            if (cmd.arm && !pend && !armed && (st != ST_RXACC)) armed <= 1'b1;
            if (cmd.drop && pend) begin
                pend     <= 1'b0;
                is_setup <= 1'b0;
                cnt      <= '0;
                rptr     <= '0;
            end
            if (cmd.halt_set) halt <= 1'b1;
            if (cmd.halt_clr) halt <= 1'b0;

            // packet side, takes priority
            case (st)
                ST_IDLE, ST_WAIT: begin
                    if (tok_valid) begin
                        case (tk)
                            TOK_SETUP: begin
                                st       <= ST_RXACC;
                                rx_setup <= 1'b1;
                                ovf      <= 1'b0;
                                cnt      <= '0;
                                rptr     <= '0;
                                armed    <= 1'b0;
                                pend     <= 1'b0;
                                is_setup <= 1'b0;
                            end
                            TOK_OUT: begin
                                if (!halt && !armed && !pend && cnt == '0) begin
                                    st       <= ST_RXACC;
                                    rx_setup <= 1'b0;
                                    ovf      <= 1'b0;
                                end else begin
                                    st <= ST_RXDROP;
                                end
                            end
                            TOK_IN: begin
                                if (halt) begin
                                    hs_valid <= 1'b1;
                                    hs_code  <= HS_STALL;
                                    st       <= ST_IDLE;
                                end else if (armed) begin
                                    tx_pkt    <= 1'b1;
                                    tx_len    <= cnt;
                                    tx_toggle <= tog;
                                    tidx      <= '0;
                                    st        <= (cnt == '0) ? ST_WAIT : ST_TX;
                                end else begin
                                    hs_valid <= 1'b1;
                                    hs_code  <= HS_NAK;
                                    st       <= ST_IDLE;
                                end
                            end
                            default: st <= ST_IDLE;
                        endcase
                    end else if (st == ST_WAIT && host_ack) begin
                        tog   <= ~tog;
                        armed <= 1'b0;
                        cnt   <= '0;
                        st    <= ST_IDLE;
                    end
                end
                ST_RXACC: begin
                    if (rx_valid) begin
                        if (room) cnt <= cnt + CW'(1);
                        else      ovf <= 1'b1;
                    end else if (rx_end) begin
                        st <= ST_IDLE;
                        if (!rx_crc_ok || ovf) begin
                            cnt <= '0;
                        end else if (rx_setup) begin
                            hs_valid <= 1'b1;
                            hs_code  <= HS_ACK;
                            pend     <= 1'b1;
                            is_setup <= 1'b1;
                            tog      <= 1'b1;
                            halt     <= 1'b0;
                            rptr     <= '0;
                        end else if (rx_toggle == tog) begin
                            hs_valid <= 1'b1;
                            hs_code  <= HS_ACK;
                            pend     <= 1'b1;
                            tog      <= ~tog;
                            rptr     <= '0;
                        end else begin
                            hs_valid <= 1'b1;
                            hs_code  <= HS_ACK;
                            cnt      <= '0;
                        end
                    end
                end
                ST_RXDROP: begin
                    if (rx_end) begin
                        st <= ST_IDLE;
                        if (rx_crc_ok) begin
                            hs_valid <= 1'b1;
                            hs_code  <= halt ? HS_STALL : HS_NAK;
                        end
                    end
                end
                ST_TX: begin
                    tx_valid <= 1'b1;
                    tx_data  <= mem_rdata_tx;
                    tidx     <= tidx + CW'(1);
                    if (tidx + CW'(1) == cnt) st <= ST_WAIT;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R10: count never exceeds the buffer size
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R6: handshake and packet start are exclusive
    p_hs_or_pkt_r6: assert property (@(posedge clk) disable iff (rst)
        !(hs_valid && tx_pkt));

    // R9: halted endpoint stalls an IN
    p_halt_in_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && tok_valid && tk == TOK_IN && halt)
        |=> (hs_valid && hs_code == HS_STALL && !tx_pkt));

    // R5: unarmed endpoint NAKs an IN
    p_unarmed_in_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && tok_valid && tk == TOK_IN && !halt && !armed)
        |=> (hs_valid && hs_code == HS_NAK));

    // R8: host acknowledgement flips the sequence bit and disarms
    p_ack_flip_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && !tok_valid && host_ack)
        |=> (tog != $past(tog) && !armed && cnt == '0));

    // R2: good SETUP sets DATA1, lifts halt, marks pending
    p_setup_done_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RXACC && !rx_valid && rx_end && rx_setup && rx_crc_ok && !ovf)
        |=> (tog && !halt && pend && is_setup && hs_valid && hs_code == HS_ACK));

    // R4: mismatched OUT is acknowledged but dropped
    p_mismatch_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RXACC && !rx_valid && rx_end && !rx_setup && rx_crc_ok && !ovf
         && rx_toggle != tog)
        |=> (!pend && cnt == '0 && $stable(tog) && hs_valid && hs_code == HS_ACK));
endmodule

// File: rtl/ep0c_top.sv
module ep0c_top
    import ep0c_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tok_valid,
    input  logic [1:0]    tok_kind,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_end,
    input  logic          rx_toggle,
    input  logic          rx_crc_ok,
    input  logic          host_ack,
    output logic          hs_valid,
    output logic [1:0]    hs_code,
    output logic          tx_pkt,
    output logic [CW-1:0] tx_len,
    output logic          tx_toggle,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    input  logic          mcu_sel,
    input  logic          mcu_we,
    input  logic [1:0]    mcu_addr,
    input  logic [7:0]    mcu_wdata,
    output logic [7:0]    mcu_rdata
);
    mcu_cmd_t      cmd;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic [AW-1:0] raddr_mcu;
    logic [AW-1:0] raddr_tx;
    logic [DW-1:0] rdata_mcu;
    logic [DW-1:0] rdata_tx;
    logic [CW-1:0] cnt;
    logic          pend;
    logic          is_setup;
    logic          halt;
    logic          armed;
    logic          tog;

    ep0c_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (raddr_mcu),
        .rdata_a (rdata_mcu),
        .raddr_b (raddr_tx),
        .rdata_b (rdata_tx)
    );

    ep0c_mcu #(.CW(CW)) u_mcu (
        .sel   (mcu_sel),
        .we    (mcu_we),
        .addr  (mcu_addr),
        .wdata (mcu_wdata),
        .cnt   (cnt),
        .pend  (pend),
        .setup (is_setup),
        .halt  (halt),
        .armed (armed),
        .tog   (tog),
        .rbyte (rdata_mcu),
        .cmd   (cmd),
        .rdata (mcu_rdata)
    );

    ep0c_proto #(.DEPTH(DEPTH)) u_proto (
        .clk           (clk),
        .rst           (rst),
        .tok_valid     (tok_valid),
        .tok_kind      (tok_kind),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_end        (rx_end),
        .rx_toggle     (rx_toggle),
        .rx_crc_ok     (rx_crc_ok),
        .host_ack      (host_ack),
        .cmd           (cmd),
        .hs_valid      (hs_valid),
        .hs_code       (hs_code),
        .tx_pkt        (tx_pkt),
        .tx_len        (tx_len),
        .tx_toggle     (tx_toggle),
        .tx_valid      (tx_valid),
        .tx_data       (tx_data),
        .mem_we        (mem_we),
        .mem_waddr     (mem_waddr),
        .mem_wdata     (mem_wdata),
        .mem_raddr_mcu (raddr_mcu),
        .mem_raddr_tx  (raddr_tx),
        .mem_rdata_tx  (rdata_tx),
        .cnt           (cnt),
        .pend          (pend),
        .is_setup      (is_setup),
        .halt          (halt),
        .armed         (armed),
        .tog           (tog)
    );
endmodule

// File: tb/ep0c_top_tb.sv
module ep0c_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tok_valid = 0;
    logic [1:0] tok_kind = 0;
    logic       rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic       rx_end = 0;
    logic       rx_toggle = 0;
    logic       rx_crc_ok = 0;
    logic       host_ack = 0;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       tx_pkt;
    logic [4:0] tx_len;
    logic       tx_toggle;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       mcu_sel = 0;
    logic       mcu_we = 0;
    logic [1:0] mcu_addr = 0;
    logic [7:0] mcu_wdata = 0;
    logic [7:0] mcu_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ep0c_top u_dut (
        .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
        .rx_toggle(rx_toggle), .rx_crc_ok(rx_crc_ok), .host_ack(host_ack),
        .hs_valid(hs_valid), .hs_code(hs_code), .tx_pkt(tx_pkt),
        .tx_len(tx_len), .tx_toggle(tx_toggle), .tx_valid(tx_valid),
        .tx_data(tx_data), .mcu_sel(mcu_sel), .mcu_we(mcu_we),
        .mcu_addr(mcu_addr), .mcu_wdata(mcu_wdata), .mcu_rdata(mcu_rdata)
    );

    // ---------------- behavioural reference model ----------------
    int         ms;            // 0 idle 1 receive 2 refuse 3 send 4 await
    bit         m_tog, m_halt, m_armed, m_pend, m_setup, m_rxsetup, m_ovf;
    logic [7:0] mb[$];
    int         m_rptr, m_tidx;
    bit         m_hsv, m_txp, m_txv, m_txt;
    int         m_hsc, m_txl;
    logic [7:0] m_txd;

    always @(posedge clk) begin
        if (rst) begin
            ms = 0; m_tog = 0; m_halt = 0; m_armed = 0; m_pend = 0;
            m_setup = 0; m_rxsetup = 0; m_ovf = 0; mb.delete();
            m_rptr = 0; m_tidx = 0; m_hsv = 0; m_txp = 0; m_txv = 0;
            m_hsc = 0; m_txl = 0; m_txt = 0; m_txd = 0;
        end else begin
            int  ocnt;
            bit  ohalt, oarmed, opend, otog;
            ocnt = mb.size(); ohalt = m_halt; oarmed = m_armed;
            opend = m_pend; otog = m_tog;
            m_hsv = 0; m_txp = 0; m_txv = 0;
            if (mcu_sel && mcu_we && mcu_addr == 0 && !oarmed && !opend
                && ms != 1 && ocnt < 16)
                mb.push_back(mcu_wdata);
            if (mcu_sel && !mcu_we && mcu_addr == 0 && opend && m_rptr < ocnt)
                m_rptr++;
            if (mcu_sel && mcu_we && mcu_addr == 1) begin
                if (mcu_wdata[0] && !opend && !oarmed && ms != 1) m_armed = 1;
                if (mcu_wdata[1] && opend) begin
                    m_pend = 0; m_setup = 0; mb.delete(); m_rptr = 0;
                end
                if (mcu_wdata[2]) m_halt = 1;
                if (mcu_wdata[3]) m_halt = 0;
            end
            if (ms == 0 || ms == 4) begin
                if (tok_valid) begin
                    if (tok_kind == 2) begin
                        ms = 1; m_rxsetup = 1; m_ovf = 0; mb.delete();
                        m_rptr = 0; m_armed = 0; m_pend = 0; m_setup = 0;
                    end else if (tok_kind == 0) begin
                        if (!ohalt && !oarmed && !opend && ocnt == 0) begin
                            ms = 1; m_rxsetup = 0; m_ovf = 0;
                        end else ms = 2;
                    end else if (tok_kind == 1) begin
                        if (ohalt) begin m_hsv = 1; m_hsc = 2; ms = 0; end
                        else if (oarmed) begin
                            m_txp = 1; m_txl = ocnt; m_txt = otog; m_tidx = 0;
                            ms = (ocnt == 0) ? 4 : 3;
                        end else begin m_hsv = 1; m_hsc = 1; ms = 0; end
                    end else ms = 0;
                end else if (ms == 4 && host_ack) begin
                    m_tog = !otog; m_armed = 0; mb.delete(); ms = 0;
                end
            end else if (ms == 1) begin
                if (rx_valid) begin
                    if (mb.size() < 16) mb.push_back(rx_data);
                    else m_ovf = 1;
                end else if (rx_end) begin
                    ms = 0;
                    if (!rx_crc_ok || m_ovf) mb.delete();
                    else if (m_rxsetup) begin
                        m_hsv = 1; m_hsc = 0; m_pend = 1; m_setup = 1;
                        m_tog = 1; m_halt = 0; m_rptr = 0;
                    end else if (rx_toggle == otog) begin
                        m_hsv = 1; m_hsc = 0; m_pend = 1; m_tog = !otog; m_rptr = 0;
                    end else begin
                        m_hsv = 1; m_hsc = 0; mb.delete();
                    end
                end
            end else if (ms == 2) begin
                if (rx_end) begin
                    ms = 0;
                    if (rx_crc_ok) begin m_hsv = 1; m_hsc = ohalt ? 2 : 1; end
                end
            end else if (ms == 3) begin
                m_txv = 1; m_txd = mb[m_tidx]; m_tidx++;
                if (m_tidx == mb.size()) ms = 4;
            end
        end
    end

    // ---------------- per-cycle comparison and monitor ----------------
    int         hs_seen = 0;
    int         last_hs = -1;
    int         pkt_seen = 0;
    int         last_len = -1;
    int         last_tog = -1;
    logic [7:0] txq[$];

    always @(negedge clk) begin
        if (!rst && !done) begin
            n_tests++;
            if (hs_valid !== m_hsv || (m_hsv && hs_code !== 2'(m_hsc))) begin
                n_fail++;
                $display("FAIL R5 handshake: actual %0b/%0d expected %0b/%0d",
                         hs_valid, hs_code, m_hsv, m_hsc);
            end
            if (tx_pkt !== m_txp || (m_txp && (tx_len !== 5'(m_txl) || tx_toggle !== m_txt))) begin
                n_fail++;
                $display("FAIL R6 packet start: actual %0b len %0d tog %0b expected %0b len %0d tog %0b",
                         tx_pkt, tx_len, tx_toggle, m_txp, m_txl, m_txt);
            end
            if (tx_valid !== m_txv || (m_txv && tx_data !== m_txd)) begin
                n_fail++;
                $display("FAIL R6 tx byte: actual %0b/%02h expected %0b/%02h",
                         tx_valid, tx_data, m_txv, m_txd);
            end
            if (mcu_sel && !mcu_we) begin
                logic [7:0] e;
                bit         cmp;
                cmp = 1; e = 0;
                case (mcu_addr)
                    2'd0: begin
                        cmp = m_pend && m_rptr < mb.size();
                        if (cmp) e = mb[m_rptr];
                    end
                    2'd1: e = {m_halt, m_setup, m_pend, 5'(mb.size())};
                    2'd2: e = {6'b0, m_tog, m_armed};
                    default: e = 0;
                endcase
                if (cmp && mcu_rdata !== e) begin
                    n_fail++;
                    $display("FAIL R11 register read addr %0d: actual %02h expected %02h",
                             mcu_addr, mcu_rdata, e);
                end
            end
            if (hs_valid) begin hs_seen++; last_hs = hs_code; end
            if (tx_pkt) begin pkt_seen++; last_len = tx_len; last_tog = tx_toggle; end
            if (tx_valid) txq.push_back(tx_data);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic token(int k);
        tok_valid = 1; tok_kind = 2'(k); step(); tok_valid = 0;
    endtask

    task automatic data_pkt(int n, int base, bit tg, bit crc);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_data = 8'(base + i); step();
        end
        rx_valid = 0;
        rx_end = 1; rx_toggle = tg; rx_crc_ok = crc; step();
        rx_end = 0; rx_crc_ok = 0;
    endtask

    task automatic mwr(int a, int d);
        mcu_sel = 1; mcu_we = 1; mcu_addr = 2'(a); mcu_wdata = 8'(d); step();
        mcu_sel = 0; mcu_we = 0;
    endtask

    task automatic mrd(int a, output int v);
        mcu_sel = 1; mcu_we = 0; mcu_addr = 2'(a); #2; v = mcu_rdata; step();
        mcu_sel = 0;
    endtask

    task automatic expect_hs(string req, int code);
        idle(2);
        check(req, "handshake count", hs_seen, 1);
        check(req, "handshake code", last_hs, code);
        hs_seen = 0; last_hs = -1;
    endtask

    task automatic expect_quiet(string req);
        idle(2);
        check(req, "no handshake", hs_seen, 0);
        hs_seen = 0;
    endtask

    task automatic expect_tx(string req, int len, int tg, int base);
        idle(len + 3);
        check(req, "packet count", pkt_seen, 1);
        check(req, "packet length", last_len, len);
        check(req, "packet toggle", last_tog, tg);
        check(req, "bytes sent", txq.size(), len);
        for (int i = 0; i < len && i < txq.size(); i++)
            check(req, "byte value", txq[i], (base + i) & 8'hff);
        pkt_seen = 0; txq.delete();
    endtask

    task automatic reg_is(string req, int a, int exp);
        int v;
        mrd(a, v);
        check(req, $sformatf("register %0d", a), v, exp);
    endtask

    task automatic read_bytes(string req, int n, int base);
        int v;
        for (int i = 0; i < n; i++) begin
            mrd(0, v);
            check(req, "read byte", v, (base + i) & 8'hff);
        end
    endtask

    // ---------------- scenarios ----------------
    initial begin
        idle(3);
        rst = 0;
        idle(1);
        // R1: quiet outputs and zero registers after reset
        check("R1", "hs_valid", hs_valid, 0);
        check("R1", "tx_pkt", tx_pkt, 0);
        reg_is("R1", 1, 0);
        reg_is("R1", 2, 0);

        // R2: SETUP of 8 bytes
        token(2); data_pkt(8, 8'h10, 0, 1);
        expect_hs("R2", 0);
        reg_is("R2", 1, 8 + 32 + 64);
        reg_is("R2", 2, 2);
        read_bytes("R2", 8, 8'h10);
        mwr(1, 2);
        reg_is("R11", 1, 0);

        // R5: IN with nothing armed
        token(1); expect_hs("R5", 1);

        // R6 / R7 / R8: load, send, replay, acknowledge
        mwr(0, 8'hA0); mwr(0, 8'hA1); mwr(0, 8'hA2); mwr(1, 1);
        reg_is("R11", 2, 3);
        token(1); expect_tx("R6", 3, 1, 8'hA0);
        token(1); expect_tx("R7", 3, 1, 8'hA0);
        host_ack = 1; step(); host_ack = 0; idle(1);
        reg_is("R8", 2, 0);
        reg_is("R8", 1, 0);

        // R3: OUT with matching toggle 0
        token(0); data_pkt(4, 8'h30, 0, 1);
        expect_hs("R3", 0);
        reg_is("R3", 1, 4 + 32);
        reg_is("R3", 2, 2);
        // R5: OUT while data is pending is refused and leaves data alone
        token(0); data_pkt(2, 8'h77, 1, 1);
        expect_hs("R5", 1);
        reg_is("R5", 1, 4 + 32);
        // R11: byte write ignored while pending
        mwr(0, 8'h55);
        reg_is("R11", 1, 4 + 32);
        read_bytes("R3", 4, 8'h30);
        mwr(1, 2);

        // R4: toggle mismatch (expected 1, sent 0)
        token(0); data_pkt(2, 8'h40, 0, 1);
        expect_hs("R4", 0);
        reg_is("R4", 1, 0);
        reg_is("R4", 2, 2);

        // R9: halt
        mwr(1, 4);
        reg_is("R9", 1, 128);
        token(1); expect_hs("R9", 2);
        token(0); data_pkt(1, 8'h01, 1, 1); expect_hs("R9", 2);
        mwr(1, 8);
        token(1); expect_hs("R9", 1);
        // R2: SETUP lifts halt
        mwr(1, 4);
        token(2); data_pkt(8, 8'h60, 0, 1);
        expect_hs("R2", 0);
        reg_is("R2", 1, 8 + 32 + 64);
        mwr(1, 2);

        // R10: bad check, overflow, and the 16-byte boundary
        token(0); data_pkt(3, 8'h80, 1, 0); expect_quiet("R10");
        reg_is("R10", 1, 0);
        token(0); data_pkt(17, 8'h90, 1, 1); expect_quiet("R10");
        reg_is("R10", 1, 0);
        token(0); data_pkt(16, 8'hC0, 1, 1); expect_hs("R10", 0);
        reg_is("R10", 1, 16 + 32);
        read_bytes("R10", 16, 8'hC0);
        mwr(1, 2);

        // R6: zero-length IN
        mwr(1, 1);
        token(1); expect_tx("R6", 0, 0, 0);
        host_ack = 1; step(); host_ack = 0; idle(1);
        reg_is("R8", 2, 2);

        // R3: zero-length OUT
        token(0); data_pkt(0, 0, 1, 1); expect_hs("R3", 0);
        reg_is("R3", 1, 32);
        mwr(1, 2);
        idle(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule